// File: doc/BRIEF.md
# Pipelined Shift-Add Multiplier

This block multiplies two unsigned integers through a chain of identical pipeline stages. Every stage takes a fixed-width slice from the bottom of the remaining multiplier and multiplies it by the full current multiplicand. It adds that small product into a partial sum that moves down the chain. It then hands on the multiplicand shifted left by the slice width and the multiplier shifted right by the same amount. The first stage starts from a partial sum of zero. The partial sum that leaves the last stage is the product.

The operand width and the stage count are parameters, and the slice width is the operand width divided by the stage count. A valid bit travels beside the data in every stage. A new operand pair can be issued on every clock, there are no stalls, and results leave in the order they were issued. A parameter selects the output width: either the full double-width product, or only its low half (the product taken modulo 2 to the power of the operand width). Reset is synchronous and empties the pipeline.

Top module: `pipe_mul`

## Requirements
- R1: With the wide output selected, `prod` equals the unsigned product `opa * opb` over the full 2*OPW bits.
- R2: Each stage consumes exactly OPW/NSTG bits of the multiplier, so after stage k (counting from 0) the top (k+1)*OPW/NSTG bits of the multiplier it passes on are zero.
- R3: The partial sum never decreases from one stage to the next, and a multiplier with only its lowest slice nonzero yields `opa` times that slice.
- R4: A zero in either operand yields a zero product.
- R5: `done` is high exactly NSTG cycles after the cycle in which `start` was sampled high, and low in every cycle that no issued operation reaches.
- R6: A synchronous reset clears `done` by the next clock, and every operation in flight when reset was applied is dropped.
- R7: One operation per cycle is accepted with no stalls; back-to-back results come out in issue order, and at most NSTG operations are in flight.
- R8: With the narrow output selected, `prod` is OPW bits wide and equals `(opa * opb) mod 2^OPW`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Issue an operation with the operands on this cycle |
| opa | input | OPW | Multiplicand |
| opb | input | OPW | Multiplier |
| prod | output | OUT_W | Product (2*OPW bits wide, or OPW bits when narrow) |
| done | output | 1 | `prod` holds the result of the operation issued NSTG cycles earlier |

## Verification
A worked case with small operands checks that slices are taken from the bottom and accumulated in order. Zero and all-ones operands test both ends of the range and carries across the full width. A multiplier whose only nonzero bits lie in the lowest slice shows that the first stage adds correctly and that later stages add nothing. Long back-to-back random streams, streams with bubbles, and a reset applied in the middle of a stream show the latency, the ordering and the flushing behaviour. Comparing a wide and a narrow instance on the same stream shows the truncation.

// File: rtl/pipe_mul_pkg.sv
package pipe_mul_pkg;
   // default shape of the multiplier
   localparam int unsigned DEF_OPW  = 16;
   localparam int unsigned DEF_NSTG = 4;

   // output width variants
   typedef enum logic {
      OUT_NARROW = 1'b0,
      OUT_WIDE   = 1'b1
   } out_mode_e;
endpackage

// File: rtl/pipe_mul_stage.sv
module pipe_mul_stage #(
   parameter int unsigned OPW  = 16,
   parameter int unsigned NSTG = 4,
   parameter int unsigned IDX  = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_vld,
   input  logic [2*OPW-1:0]   in_mcand,
   input  logic [OPW-1:0]     in_mplier,
   input  logic [2*OPW-1:0]   in_psum,
   output logic               out_vld,
   output logic [2*OPW-1:0]   out_mcand,
   output logic [OPW-1:0]     out_mplier,
   output logic [2*OPW-1:0]   out_psum
);
   localparam int unsigned SLW  = OPW / NSTG;
   localparam int unsigned PW   = 2 * OPW;
   localparam int unsigned LEFT = OPW - (IDX + 1) * SLW;

   logic [SLW-1:0] slice;
   logic [PW-1:0]  slice_prod;

   assign slice      = in_mplier[SLW-1:0];
   assign slice_prod = in_mcand * {{(PW-SLW){1'b0}}, slice};

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld    <= 1'b0;
         out_mcand  <= '0;
         out_mplier <= '0;
         out_psum   <= '0;
      end else begin
         out_vld    <= in_vld;
         out_mcand  <= in_mcand << SLW;
         out_mplier <= in_mplier >> SLW;
         out_psum   <= in_psum + slice_prod;
      end
   end

   // R3: the running sum only grows as it moves down the chain
   p_psum_grows_r3: assert property (@(posedge clk) disable iff (rst)
      (out_vld && $past(in_vld)) |-> (out_psum >= $past(in_psum)))
      else $error("stage %0d: partial sum decreased", IDX);

   // R2: the consumed top bits of the multiplier are zero
   p_mplier_drain_r2: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> ((out_mplier >> LEFT) == '0))
      else $error("stage %0d: multiplier not drained", IDX);
endmodule

// File: rtl/pipe_mul_trim.sv
module pipe_mul_trim #(
   parameter int unsigned OPW   = 16,
   parameter int unsigned OUT_W = 32
) (
   input  logic [2*OPW-1:0] full,
   output logic [OUT_W-1:0] res
);
   generate
      if (OUT_W == 2 * OPW) begin : g_wide
         assign res = full;
      end else if (OUT_W == OPW) begin : g_narrow
         assign res = full[OPW-1:0];
      end else begin : g_bad
         $error("pipe_mul_trim: OUT_W must be OPW or 2*OPW");
      end
   endgenerate
endmodule

// File: rtl/pipe_mul.sv
module pipe_mul #(
   parameter int unsigned OPW      = pipe_mul_pkg::DEF_OPW,
   parameter int unsigned NSTG     = pipe_mul_pkg::DEF_NSTG,
   parameter bit          WIDE_OUT = 1'b1,
   parameter int unsigned OUT_W    = WIDE_OUT ? 2 * OPW : OPW
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [OPW-1:0]   opa,
   input  logic [OPW-1:0]   opb,
   output logic [OUT_W-1:0] prod,
   output logic             done
);
   localparam int unsigned PW  = 2 * OPW;
   localparam int unsigned CNW = $clog2(NSTG + 2) + 1;

   // elaboration checks on the shape
   generate
      if (NSTG == 0 || (OPW % NSTG) != 0) begin : g_bad_split
         $error("pipe_mul: OPW must be a nonzero multiple of NSTG");
      end
      if (OUT_W != (WIDE_OUT ? 2 * OPW : OPW)) begin : g_bad_out
         $error("pipe_mul: OUT_W does not match WIDE_OUT");
      end
   endgenerate

   // chain links: index k feeds stage k
   logic [NSTG:0]           vld_c;
   logic [PW-1:0]           mcand_c  [NSTG+1];
   logic [OPW-1:0]          mplier_c [NSTG+1];
   logic [PW-1:0]           psum_c   [NSTG+1];

   assign vld_c[0]    = start;
   assign mcand_c[0]  = {{OPW{1'b0}}, opa};
   assign mplier_c[0] = opb;
   assign psum_c[0]   = '0;

   generate
      for (genvar k = 0; k < NSTG; k++) begin : g_stage
         pipe_mul_stage #(
            .OPW  (OPW),
            .NSTG (NSTG),
            .IDX  (k)
         ) u_stage (
            .clk        (clk),
            .rst        (rst),
            .in_vld     (vld_c[k]),
            .in_mcand   (mcand_c[k]),
            .in_mplier  (mplier_c[k]),
            .in_psum    (psum_c[k]),
            .out_vld    (vld_c[k+1]),
            .out_mcand  (mcand_c[k+1]),
            .out_mplier (mplier_c[k+1]),
            .out_psum   (psum_c[k+1])
         );
      end
   endgenerate

   pipe_mul_trim #(
      .OPW   (OPW),
      .OUT_W (OUT_W)
   ) u_trim (
      .full (psum_c[NSTG]),
      .res  (prod)
   );

   assign done = vld_c[NSTG];

   // in-flight tracker used only by the checks below
   logic [CNW-1:0] inflight;
   always_ff @(posedge clk) begin
      if (rst) inflight <= '0;
      else     inflight <= inflight + CNW'(start) - CNW'(done);
   end

   // R7: the chain never holds more than NSTG operations
   p_inflight_bound_r7: assert property (@(posedge clk) disable iff (rst)
      inflight <= CNW'(NSTG))
      else $error("pipe_mul: too many operations in flight");

   // R5: a result only appears for an operation that was issued
   p_done_needs_issue_r5: assert property (@(posedge clk) disable iff (rst)
      done |-> (inflight != '0))
      else $error("pipe_mul: done without an issued operation");

   // R6: reset empties the output stage by the next edge
   p_reset_clears_r6: assert property (@(posedge clk)
      rst |=> !done)
      else $error("pipe_mul: done high after reset");
endmodule

// File: tb/pipe_mul_bench.sv
module pipe_mul_bench;
   localparam int OPW  = 16;
   localparam int NSTG = 4;
   localparam int DEP  = 1024;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              start = 1'b0;
   logic [OPW-1:0]    opa = '0;
   logic [OPW-1:0]    opb = '0;
   logic [2*OPW-1:0]  prod_w;
   logic              done_w;
   logic [OPW-1:0]    prod_n;
   logic              done_n;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit chk_en = 1'b0;

   // expected results indexed by the cycle they are due
   bit               exp_v [DEP];
   logic [2*OPW-1:0] exp_p [DEP];
   string            exp_t [DEP];

   always #5 clk = ~clk;

   pipe_mul #(.OPW(OPW), .NSTG(NSTG), .WIDE_OUT(1'b1)) u_pipe_mul (
      .clk(clk), .rst(rst), .start(start), .opa(opa), .opb(opb),
      .prod(prod_w), .done(done_w));

   pipe_mul #(.OPW(OPW), .NSTG(NSTG), .WIDE_OUT(1'b0)) u_pipe_mul_narrow (
      .clk(clk), .rst(rst), .start(start), .opa(opa), .opb(opb),
      .prod(prod_n), .done(done_n));

   always @(posedge clk) cyc++;

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // compare against the model away from the active edge
   always @(negedge clk) begin
      if (chk_en) begin
         int i;
         i = cyc % DEP;
         check({exp_t[i], " done"}, 64'(done_w), 64'(exp_v[i]));
         check({exp_t[i], " done narrow"}, 64'(done_n), 64'(exp_v[i]));
         if (exp_v[i]) begin
            check(exp_t[i], 64'(prod_w), 64'(exp_p[i]));
            check("R8 narrow", 64'(prod_n), 64'(exp_p[i][OPW-1:0]));
         end
         exp_v[i] = 1'b0;
         exp_t[i] = "R5 idle";
      end
   end

   // drive one cycle; result due NSTG edges after sampling
   task automatic issue(bit v, logic [OPW-1:0] a, logic [OPW-1:0] b, string tag);
      int j;
      @(posedge clk);
      #2;
      start = v;
      opa   = a;
      opb   = b;
      if (v) begin
         j = (cyc + NSTG) % DEP;
         exp_v[j] = 1'b1;
         exp_p[j] = (2*OPW)'(a) * (2*OPW)'(b);
         exp_t[j] = tag;
      end
   endtask

   task automatic do_reset();
      @(posedge clk);
      #2;
      start  = 1'b0;
      rst    = 1'b1;
      chk_en = 1'b0;
      for (int k = 0; k < DEP; k++) begin
         exp_v[k] = 1'b0;
         exp_t[k] = "R6 after reset";
      end
      @(posedge clk);
      @(posedge clk);
      #2;
      rst    = 1'b0;
      chk_en = 1'b1;
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int k = 0; k < DEP; k++) begin
         exp_v[k] = 1'b0;
         exp_t[k] = "R6 reset state";
      end
      do_reset();
      // R1 worked case: 11 * 7
      issue(1'b1, 16'h000B, 16'h0007, "R1 small");
      // R4 zero operands
      issue(1'b1, 16'h0000, 16'hFFFF, "R4 zero a");
      issue(1'b1, 16'hFFFF, 16'h0000, "R4 zero b");
      // R1 full-range carries
      issue(1'b1, 16'hFFFF, 16'hFFFF, "R1 max");
      // R3 only the lowest slice of the multiplier set
      issue(1'b1, 16'hABCD, 16'h000F, "R3 low slice");
      // R2 only the top slice set
      issue(1'b1, 16'h1234, 16'hF000, "R2 top slice");
      for (int k = 0; k < 8; k++) issue(1'b0, '0, '0, "");
      // R7 back-to-back random stream
      for (int k = 0; k < 200; k++)
         issue(1'b1, OPW'($urandom), OPW'($urandom), "R7 stream");
      // R5 bubbles between operations
      for (int k = 0; k < 100; k++)
         issue(k[0] | k[2], OPW'($urandom), OPW'($urandom), "R5 bubbles");
      // R6 reset while the chain is full
      for (int k = 0; k < NSTG; k++)
         issue(1'b1, OPW'($urandom), OPW'($urandom), "R6 dropped");
      do_reset();
      for (int k = 0; k < 8; k++) issue(1'b0, '0, '0, "");
      for (int k = 0; k < 100; k++)
         issue(1'b1, OPW'($urandom), OPW'($urandom), "R1 random");
      for (int k = 0; k < 10; k++) issue(1'b0, '0, '0, "");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule